// File: doc/BRIEF.md
# Correctable Error Log and Report Mask

This block holds two 32-bit configuration registers for one PCI Express port. The first is a sticky log of correctable link and transaction errors. The second decides which of those errors are reported. The link and transaction logic raise single-cycle event pulses. Each pulse sets its status bit, and that bit stays set until software writes a 1 to it.

The report mask may be written only once after reset. Its default value suppresses the advisory non-fatal class. For every event, the block makes a reporting decision and raises registered pulses:
- a correctable-error message request, when an unmasked event arrives;
- an uncorrectable-status update, for an unmasked advisory event;
- a device-status "correctable error detected" set, for any event at all.

Software reaches both registers through a simple configuration port. The port carries an offset, write data, byte enables and a combinational read-data bus.

Top module: `cerr_regs`

## Requirements
- R1: After reset, the log register (offset 0x110) reads 0x00000000 and the mask register (offset 0x114) reads 0x00002000. All three report pulses are low.
- R2: An event sets its log bit on the next clock edge, and the bit stays set until it is cleared. The bit positions are: receiver error 0, bad TLP 6, bad DLLP 7, replay-number rollover 8, replay-timer timeout 12, advisory non-fatal 13.
- R3: A write to offset 0x110 clears each log bit written with 1. A bit written with 0 keeps its value.
- R4: Byte enable n (bit n of cfg_be) gates the write of data bits 8n+7:8n. A clear or a mask load in a disabled byte has no effect.
- R5: The output err_cor_req pulses high for exactly one cycle after a clock edge that samples an event on a bit whose mask is 0. An event on a masked bit gives no pulse.
- R6: The first write to offset 0x114 with a nonzero byte enable loads the enabled mask bytes and locks the mask. Later writes are ignored until reset. A write with all byte enables 0 neither loads nor locks.
- R7: An advisory non-fatal event gives a one-cycle unc_status_upd pulse only when mask bit 13 is 0. When that bit is 1, the event gives no message request either.
- R8: When an event and a write-1 clear hit the same log bit on the same edge, the bit stays set.
- R9: Reserved bits (5:1, 11:9, 31:14) read 0 in both registers, even after writing ones. Any other offset reads 0.
- R10: The output corr_detected pulses for one cycle after any event, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| ev_rx_err | input | 1 | Receiver error event pulse |
| ev_bad_tlp | input | 1 | Bad TLP received event pulse |
| ev_bad_dllp | input | 1 | Bad DLLP received event pulse |
| ev_rpl_roll | input | 1 | Replay number rollover event pulse |
| ev_rpl_tmo | input | 1 | Replay timer timeout event pulse |
| ev_advisory | input | 1 | Advisory non-fatal error event pulse |
| err_cor_req | output | 1 | Correctable-error message request pulse |
| unc_status_upd | output | 1 | Uncorrectable-status update pulse for advisory errors |
| corr_detected | output | 1 | Device-status correctable-error-detected set pulse |

## Verification
The bench drives an event and a write-1 clear of the same bit on one edge; a design that lets the clear win would drop the error from the log. It tries a second mask write after a partial first write, and a write with all byte enables 0. A design that is not write-once, or that counts the empty write as the lock, would show a wrong mask. It sends advisory events under both the default mask and a cleared mask. A design that tied the detected pulse to the mask, or let a masked advisory event reach the uncorrectable update, would show a pulse that is wrong or missing. It also writes all ones to both registers; a design that stored reserved bits would read them back as nonzero.

// File: rtl/cerr_pkg.sv
// Package: shared widths, offsets and bit positions for the correctable
// error log/mask block. Assumes 32-bit registers, byte-granular enables.
package cerr_pkg;
    localparam int REG_W   = 32;
    localparam int BE_W    = REG_W / 8;
    localparam int ADDR_W  = 12;
    localparam int NUM_EV  = 6;

    localparam logic [ADDR_W-1:0] LOG_OFF  = 12'h110;
    localparam logic [ADDR_W-1:0] MASK_OFF = 12'h114;

    // Bit positions shared by log and mask registers.
    localparam int B_RX   = 0;
    localparam int B_TLP  = 6;
    localparam int B_DLLP = 7;
    localparam int B_ROLL = 8;
    localparam int B_TMO  = 12;
    localparam int B_ADV  = 13;

    localparam logic [REG_W-1:0] IMPL_BITS =
        (REG_W'(1) << B_RX)   | (REG_W'(1) << B_TLP)  |
        (REG_W'(1) << B_DLLP) | (REG_W'(1) << B_ROLL) |
        (REG_W'(1) << B_TMO)  | (REG_W'(1) << B_ADV);

    // Advisory errors masked out of reset.
    localparam logic [REG_W-1:0] MASK_RST = REG_W'(1) << B_ADV;
endpackage

// File: rtl/cerr_log.sv
// Module: sticky write-1-to-clear error log.
// Each implemented bit is set by its event and cleared by a clear strobe;
// a set on the same edge wins. Unimplemented bits are constant 0.
module cerr_log #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            if (IMPL[g]) begin : g_impl
                logic bit_q;
                // Purpose: hold one sticky flag, event has priority over clear.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        bit_q <= 1'b0;
                    else
                        bit_q <= set_i[g] | (bit_q & ~clr_i[g]);
                end
                assign q_o[g] = bit_q;
            end else begin : g_rsvd
                assign q_o[g] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/cerr_mask.sv
// Module: write-once report mask.
// The first write with any byte enabled loads those bytes (implemented bits
// only) and sets a lock; further writes are dropped until reset.
module cerr_mask #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '1,
    parameter logic [W-1:0] RST  = '0,
    localparam int          NB   = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [NB-1:0] be_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  q_o,
    output logic          locked_o
);
    logic [W-1:0] mask_q;
    logic         lock_q;
    logic         take;

    assign take = wr_i && (|be_i) && !lock_q;

    // Purpose: load enabled bytes on the first accepted write, then lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= RST & IMPL;
            lock_q <= 1'b0;
        end else if (take) begin
            lock_q <= 1'b1;
            for (int b = 0; b < NB; b++) begin
                if (be_i[b])
                    mask_q[b*8 +: 8] <= wdata_i[b*8 +: 8] & IMPL[b*8 +: 8];
            end
        end
    end

    assign q_o      = mask_q;
    assign locked_o = lock_q;
endmodule

// File: rtl/cerr_report.sv
// Module: reporting decision. Registers three one-cycle pulses from the
// event vector and the current mask. Assumes events are single-cycle.
module cerr_report #(
    parameter int W   = 32,
    parameter int ADV = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] mask_i,
    output logic         req_o,
    output logic         unc_o,
    output logic         det_o
);
    // Purpose: derive message request, uncorrectable update and detect flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o <= 1'b0;
            unc_o <= 1'b0;
            det_o <= 1'b0;
        end else begin
            req_o <= |(evt_i & ~mask_i);
            unc_o <= evt_i[ADV] & ~mask_i[ADV];
            det_o <= |evt_i;
        end
    end
endmodule

// File: rtl/cerr_regs.sv
// Module: top of the correctable error log/mask block for one port.
// Decodes config writes to the log (W1C) and mask (write-once) registers,
// muxes reads combinationally, and forwards events to the report stage.
module cerr_regs
    import cerr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic [BE_W-1:0]   cfg_be,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              ev_rx_err,
    input  logic              ev_bad_tlp,
    input  logic              ev_bad_dllp,
    input  logic              ev_rpl_roll,
    input  logic              ev_rpl_tmo,
    input  logic              ev_advisory,
    output logic              err_cor_req,
    output logic              unc_status_upd,
    output logic              corr_detected
);
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] be_bits;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] mask_q;
    logic             mask_locked;
    logic             st_wr;
    logic             mk_wr;

    // Purpose: place event pulses at their register bit positions.
    always_comb begin
        evt_vec         = '0;
        evt_vec[B_RX]   = ev_rx_err;
        evt_vec[B_TLP]  = ev_bad_tlp;
        evt_vec[B_DLLP] = ev_bad_dllp;
        evt_vec[B_ROLL] = ev_rpl_roll;
        evt_vec[B_TMO]  = ev_rpl_tmo;
        evt_vec[B_ADV]  = ev_advisory;
    end

    genvar gb;
    generate
        for (gb = 0; gb < BE_W; gb++) begin : g_be
            assign be_bits[gb*8 +: 8] = {8{cfg_be[gb]}};
        end
    endgenerate

    assign st_wr   = cfg_wr && (cfg_addr == LOG_OFF);
    assign mk_wr   = cfg_wr && (cfg_addr == MASK_OFF);
    assign clr_vec = st_wr ? (cfg_wdata & be_bits) : '0;

    cerr_log #(.W(REG_W), .IMPL(IMPL_BITS)) u_log (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_vec),
        .clr_i (clr_vec),
        .q_o   (status_q)
    );

    cerr_mask #(.W(REG_W), .IMPL(IMPL_BITS), .RST(MASK_RST)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (mk_wr),
        .be_i     (cfg_be),
        .wdata_i  (cfg_wdata),
        .q_o      (mask_q),
        .locked_o (mask_locked)
    );

    cerr_report #(.W(REG_W), .ADV(B_ADV)) u_rep (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_vec),
        .mask_i (mask_q),
        .req_o  (err_cor_req),
        .unc_o  (unc_status_upd),
        .det_o  (corr_detected)
    );

    // Purpose: return the addressed register, zero for any other offset.
    always_comb begin
        if (cfg_addr == LOG_OFF)
            cfg_rdata = status_q;
        else if (cfg_addr == MASK_OFF)
            cfg_rdata = mask_q;
        else
            cfg_rdata = '0;
    end
endmodule

// File: rtl/cerr_regs_chk.sv
// Module: property checker for cerr_regs, attached by bind below.
// Assumes it sees the block's event vector, stored registers and lock flag.
module cerr_regs_chk
    import cerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_vec,
    input  logic [REG_W-1:0] status_q,
    input  logic [REG_W-1:0] mask_q,
    input  logic             mask_locked,
    input  logic             st_wr,
    input  logic             err_cor_req,
    input  logic             unc_status_upd,
    input  logic             corr_detected
);
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_vec) |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));

    p_clear_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_q) & ~status_q)) |-> $past(st_wr));

    p_req_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_cor_req |-> $past(|(evt_vec & ~mask_q)));

    p_lock_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_locked |=> ($stable(mask_q) && mask_locked));

    p_unc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unc_status_upd |-> $past(evt_vec[B_ADV] && !mask_q[B_ADV]));

    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | mask_q) & ~IMPL_BITS) == '0);

    p_detect_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_vec) |=> corr_detected);
endmodule

bind cerr_regs cerr_regs_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_vec        (evt_vec),
    .status_q       (status_q),
    .mask_q         (mask_q),
    .mask_locked    (mask_locked),
    .st_wr          (st_wr),
    .err_cor_req    (err_cor_req),
    .unc_status_upd (unc_status_upd),
    .corr_detected  (corr_detected)
);

// File: tb/cerr_regs_tb_top.sv
// Bench: vector table walked by one loop, then directed reset/corner tests.
module cerr_regs_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_rdata;
    logic [5:0]  ev = '0; // {adv, tmo, roll, dllp, tlp, rx}
    logic        err_cor_req, unc_status_upd, corr_detected;
    int          total = 0;
    int          bad = 0;

    always #(CLK_P/2) clk = ~clk;

    cerr_regs dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .ev_rx_err(ev[0]), .ev_bad_tlp(ev[1]), .ev_bad_dllp(ev[2]),
        .ev_rpl_roll(ev[3]), .ev_rpl_tmo(ev[4]), .ev_advisory(ev[5]),
        .err_cor_req(err_cor_req), .unc_status_upd(unc_status_upd),
        .corr_detected(corr_detected)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [5:0]  ev;
        logic [31:0] st;
        logic [31:0] mk;
        logic        rq;
        logic        un;
        logic        dt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 12'h000, 32'h0,        4'h0, 6'b000001, 32'h0001, 32'h2000, 1'b1, 1'b0, 1'b1}, // R2 R5 rx
        '{1'b0, 12'h000, 32'h0,        4'h0, 6'b100000, 32'h2001, 32'h2000, 1'b0, 1'b0, 1'b1}, // R7 R10 adv masked
        '{1'b1, 12'h110, 32'h1,        4'hF, 6'b000000, 32'h2000, 32'h2000, 1'b0, 1'b0, 1'b0}, // R3 clear
        '{1'b1, 12'h110, 32'h0,        4'hF, 6'b000000, 32'h2000, 32'h2000, 1'b0, 1'b0, 1'b0}, // R3 write 0
        '{1'b1, 12'h110, 32'h2000,     4'h1, 6'b000000, 32'h2000, 32'h2000, 1'b0, 1'b0, 1'b0}, // R4 byte off
        '{1'b1, 12'h110, 32'hFFFFFFFF, 4'hF, 6'b000000, 32'h0000, 32'h2000, 1'b0, 1'b0, 1'b0}, // R3 all
        '{1'b1, 12'h114, 32'h00000041, 4'h1, 6'b000000, 32'h0000, 32'h2041, 1'b0, 1'b0, 1'b0}, // R6 R4 load
        '{1'b1, 12'h114, 32'h0,        4'hF, 6'b000000, 32'h0000, 32'h2041, 1'b0, 1'b0, 1'b0}, // R6 locked
        '{1'b0, 12'h000, 32'h0,        4'h0, 6'b000010, 32'h0040, 32'h2041, 1'b0, 1'b0, 1'b1}, // R5 masked tlp
        '{1'b0, 12'h000, 32'h0,        4'h0, 6'b011100, 32'h11C0, 32'h2041, 1'b1, 1'b0, 1'b1}, // R2 multi
        '{1'b1, 12'h110, 32'h1,        4'hF, 6'b000001, 32'h11C1, 32'h2041, 1'b0, 1'b0, 1'b1}, // R8 set wins
        '{1'b1, 12'h110, 32'hFFFFFFFF, 4'hF, 6'b000000, 32'h0000, 32'h2041, 1'b0, 1'b0, 1'b0}, // R3 clear all
        '{1'b0, 12'h000, 32'h0,        4'h0, 6'b100000, 32'h2000, 32'h2041, 1'b0, 1'b0, 1'b1}  // R7 adv masked
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, input string tag, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    // One clocked operation; leaves inputs idle at the following negedge.
    task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input logic [3:0] b, input logic [5:0] e);
        @(negedge clk);
        cfg_wr = w; cfg_addr = a; cfg_wdata = d; cfg_be = b; ev = e;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0; cfg_be = '0; ev = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 req", {31'b0, err_cor_req}, 32'h0);
        chk("R1 unc", {31'b0, unc_status_upd}, 32'h0);
        chk("R1 det", {31'b0, corr_detected}, 32'h0);
        rd(12'h110, "R1 log", 32'h0);
        rd(12'h114, "R1 mask", 32'h2000);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].wr, TBL[i].addr, TBL[i].wd, TBL[i].be, TBL[i].ev);
            chk("R5 req", {31'b0, err_cor_req}, {31'b0, TBL[i].rq});
            chk("R7 unc", {31'b0, unc_status_upd}, {31'b0, TBL[i].un});
            chk("R10 det", {31'b0, corr_detected}, {31'b0, TBL[i].dt});
            rd(12'h110, "R2 R3 R4 R8 log", TBL[i].st);
            rd(12'h114, "R6 mask", TBL[i].mk);
        end
        // R5 pulse lasts one cycle
        step(1'b0, 12'h000, 32'h0, 4'h0, 6'b000001);
        @(negedge clk);
        chk("R5 pulse width", {31'b0, err_cor_req}, 32'h0);

        // R9 reserved bits and unmapped offset
        do_reset();
        step(1'b1, 12'h114, 32'hFFFFFFFF, 4'hF, 6'b000000);
        rd(12'h114, "R9 mask rsvd", 32'h31C1);
        step(1'b1, 12'h110, 32'hFFFFFFFF, 4'hF, 6'b111111);
        rd(12'h110, "R9 log rsvd", 32'h31C1);
        rd(12'h118, "R9 other offset", 32'h0);

        // R6 zero-enable write does not lock; R7 unmasked advisory
        do_reset();
        step(1'b1, 12'h114, 32'h0, 4'h0, 6'b000000);
        rd(12'h114, "R6 be0 no load", 32'h2000);
        step(1'b1, 12'h114, 32'h0, 4'hF, 6'b000000);
        rd(12'h114, "R6 first load", 32'h0);
        step(1'b0, 12'h000, 32'h0, 4'h0, 6'b100000);
        chk("R7 unc unmasked", {31'b0, unc_status_upd}, 32'h1);
        chk("R7 req unmasked", {31'b0, err_cor_req}, 32'h1);
        chk("R10 det unmasked", {31'b0, corr_detected}, 32'h1);
        rd(12'h110, "R2 adv logged", 32'h2000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule